// File: doc/BRIEF.md
# Eight-Point Inverse Cosine Transform Engine

This block turns one row or column of eight frequency-domain coefficients into eight spatial-domain samples for a video decoder. One coefficient enters per clock, qualified by a valid flag, in natural index order k = 0 to 7. Each accepted coefficient is multiplied at once by a fixed bank of seven cosine constants (cos(jπ/16) for j = 1..7, signed, 14 fraction bits). A per-output routing stage then picks one product and a sign for each of the eight output accumulators, so all eight results grow in parallel while the block streams in.

The routing for output n follows an angle (2n+1)·k modulo 32 that advances by 2n+1 on every accepted coefficient. Each output therefore walks round the same circle of cosine values at its own stride, and the angle is folded into one of the seven constants plus a sign. The DC coefficient always uses the cos(π/4) constant, which supplies its 1/√2 weight. There is no general multiplier. The same unit serves the row pass and the column pass of a 2-D transform; the transpose store sits outside it.

Once the eighth coefficient of a block has been accepted, the eight sums are rounded to nearest, clipped to the signed output range and presented together with a one-cycle done strobe. The next block may start on the very next clock.

Top module: `idct8_engine`

## Requirements
- R1: After reset, done is low and all eight output samples read zero.
- R2: For a block X[0..7] given in natural order, output n (bits [n*9 +: 9] of the sample bus) equals round(0.5·Σk c(k)·X[k]·cos((2n+1)kπ/16)), with c(0)=1/√2 and c(k)=1 otherwise, to within ±1 LSB.
- R3: A block with only the DC coefficient non-zero yields eight equal samples of X[0]·cos(π/4)/2, to within ±1 LSB.
- R4: Done is high for exactly one cycle, the cycle right after the eighth accepted coefficient of a block, and the samples are valid in that cycle.
- R5: A cycle with valid low changes no accumulation: idle cycles inside a block leave its result unchanged, and after a block the samples hold until the next block's first coefficient.
- R6: Blocks may follow each other with no idle cycle; the first coefficient of each block restarts accumulation, so no earlier block leaks into a later one.
- R7: Results beyond the 9-bit signed range clip to 255 or -256.
- R8: A block with a single non-zero coefficient at any index k, including the highest, reproduces the matching scaled cosine basis row.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous active-low reset |
| coef_valid_i | input | 1 | Coefficient on coef_i is accepted this cycle |
| coef_i | input | COEF_W (12) | Signed coefficient, natural index order |
| done_o | output | 1 | One-cycle strobe: samples hold a finished block |
| samples_o | output | 8*OUT_W (72) | Eight signed samples, output n at bits [n*OUT_W +: OUT_W] |

## Verification
The assertions take for granted that the valid flag is never unknown once reset is released and that a block is exactly eight accepted coefficients, the block itself keeping count; they also rely on the per-output angle never landing on a multiple of π/2 for a non-DC coefficient, which only holds while blocks stay aligned from reset. The stimulus therefore holds valid low until reset ends, drives only 12-bit coefficient values, and inserts idle cycles only between or inside whole blocks, never a partial block at the end of the run.

// File: rtl/idct8_pkg.sv
package idct8_pkg;

    localparam int NPT        = 8;
    localparam int CONST_FRAC = 14;
    localparam int CONST_W    = 16;
    localparam int ANG_W      = 5;
    localparam int IDX_W      = 3;
    localparam logic [IDX_W-1:0] DC_SEL = 3'd4;

    // Cosine of j*pi/16 in signed Q1.14, rounded to nearest
    function automatic logic signed [CONST_W-1:0] cos_q(input logic [IDX_W-1:0] idx);
        logic signed [CONST_W-1:0] v;
        case (idx)
            3'd1:    v = 16'sd16069;
            3'd2:    v = 16'sd15137;
            3'd3:    v = 16'sd13623;
            3'd4:    v = 16'sd11585;
            3'd5:    v = 16'sd9102;
            3'd6:    v = 16'sd6270;
            3'd7:    v = 16'sd3196;
            default: v = 16'sd0;
        endcase
        return v;
    endfunction

    typedef struct packed {
        logic             neg;
        logic             nul;
        logic [IDX_W-1:0] sel;
    } route_t;

    // Fold an angle m*pi/16 (m in 0..31) onto the first-quadrant constant set
    function automatic route_t fold_angle(input logic [ANG_W-1:0] m);
        route_t r;
        r.neg = 1'b0;
        r.nul = 1'b0;
        r.sel = '0;
        if (m <= 5'd8) begin
            r.sel = m[IDX_W-1:0];
            r.nul = (m == 5'd0) || (m == 5'd8);
        end else if (m <= 5'd16) begin
            r.sel = IDX_W'(5'd16 - m);
            r.neg = 1'b1;
            r.nul = (m == 5'd16);
        end else if (m <= 5'd24) begin
            r.sel = IDX_W'(m - 5'd16);
            r.neg = 1'b1;
            r.nul = (m == 5'd24);
        end else begin
            r.sel = IDX_W'(5'd0 - m);
        end
        return r;
    endfunction

endpackage

// File: rtl/idct8_const_bank.sv
module idct8_const_bank
    import idct8_pkg::*;
#(
    parameter int COEF_W = 12,
    parameter int PROD_W = COEF_W + CONST_W
) (
    input  logic signed [COEF_W-1:0]          coef_i,
    output logic        [NPT-1:0][PROD_W-1:0] prod_o
);

    logic signed [PROD_W-1:0] coef_ext;
    assign coef_ext = PROD_W'(coef_i);

    // Slot 0 is never routed; slots 1..7 are the seven fixed multipliers
    for (genvar j = 0; j < NPT; j++) begin : g_slot
        if (j == 0) begin : g_unused
            assign prod_o[j] = '0;
        end else begin : g_mult
            localparam logic signed [PROD_W-1:0] KVAL = PROD_W'(cos_q(IDX_W'(j)));
            logic signed [PROD_W-1:0] prod;
            assign prod      = coef_ext * KVAL;
            assign prod_o[j] = prod;
        end
    end

endmodule

// File: rtl/idct8_lane.sv
module idct8_lane
    import idct8_pkg::*;
#(
    parameter int LANE   = 0,
    parameter int COEF_W = 12,
    parameter int PROD_W = COEF_W + CONST_W,
    parameter int ACC_W  = 22,
    parameter int OUT_W  = 9
) (
    input  logic                          clk_i,
    input  logic                          rst_ni,
    input  logic                          take_i,
    input  logic                          first_i,
    input  logic                          last_i,
    input  logic [NPT-1:0][PROD_W-1:0]    prod_i,
    output logic [OUT_W-1:0]              sample_o
);

    localparam int ACC_FRAC = ACC_W - COEF_W - 3;
    localparam int DROP     = CONST_FRAC + 1 - ACC_FRAC;
    localparam int STEP     = 2 * LANE + 1;
    localparam int HALF     = 1 << (ACC_FRAC - 1);
    localparam int OUT_MAX  = (1 << (OUT_W - 1)) - 1;
    localparam logic signed [ACC_W:0] SAT_HI = (ACC_W+1)'(OUT_MAX);
    localparam logic signed [ACC_W:0] SAT_LO = -SAT_HI - 1;

    typedef struct packed {
        logic [ANG_W-1:0] phase;
        logic [ACC_W-1:0] acc;
    } lane_t;

    lane_t state_d, state_q;

    route_t                   rt;
    logic signed [PROD_W-1:0] prod_s;
    logic signed [PROD_W-1:0] prod_sh;
    logic signed [ACC_W-1:0]  term;
    logic signed [ACC_W-1:0]  acc_s;
    logic signed [ACC_W:0]    rnd;
    logic signed [ACC_W:0]    quo;

    always_comb begin
        state_d = state_q;
        acc_s   = $signed(state_q.acc);

        if (first_i) begin
            rt = '{neg: 1'b0, nul: 1'b0, sel: DC_SEL};
        end else begin
            rt = fold_angle(state_q.phase);
        end

        prod_s  = $signed(prod_i[rt.sel]);
        prod_sh = prod_s >>> DROP;
        term    = ACC_W'(prod_sh);
        if (rt.nul) begin
            term = '0;
        end
        if (rt.neg) begin
            term = -term;
        end

        if (take_i) begin
            state_d.acc   = first_i ? term : (acc_s + term);
            state_d.phase = last_i ? '0 : (state_q.phase + ANG_W'(STEP));
        end

        rnd = (ACC_W+1)'(acc_s) + (ACC_W+1)'(HALF);
        quo = rnd >>> ACC_FRAC;
        if (quo > SAT_HI) begin
            sample_o = OUT_W'(OUT_MAX);
        end else if (quo < SAT_LO) begin
            sample_o = OUT_W'(SAT_LO);
        end else begin
            sample_o = quo[OUT_W-1:0];
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    // R5
    hold_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !take_i |=> $stable(state_q.acc));

    // R5
    sample_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !take_i |=> $stable(sample_o));

    // R2
    angle_live_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (take_i && !first_i) |-> !rt.nul);

endmodule

// File: rtl/idct8_engine.sv
module idct8_engine
    import idct8_pkg::*;
#(
    parameter int COEF_W = 12,
    parameter int ACC_W  = 22,
    parameter int OUT_W  = 9
) (
    input  logic                     clk_i,
    input  logic                     rst_ni,
    input  logic                     coef_valid_i,
    input  logic [COEF_W-1:0]        coef_i,
    output logic                     done_o,
    output logic [NPT*OUT_W-1:0]     samples_o
);

    localparam int PROD_W = COEF_W + CONST_W;
    localparam int CNT_W  = $clog2(NPT);
    localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(NPT - 1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             done;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic                       first;
    logic                       last;
    logic [NPT-1:0][PROD_W-1:0] prods;

    always_comb begin
        ctl_d      = ctl_q;
        first      = (ctl_q.cnt == '0);
        last       = (ctl_q.cnt == LAST_IDX);
        ctl_d.done = coef_valid_i && last;
        if (coef_valid_i) begin
            ctl_d.cnt = ctl_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            ctl_q <= '0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign done_o = ctl_q.done;

    idct8_const_bank #(
        .COEF_W (COEF_W),
        .PROD_W (PROD_W)
    ) u_bank (
        .coef_i (coef_i),
        .prod_o (prods)
    );

    for (genvar n = 0; n < NPT; n++) begin : g_lane
        idct8_lane #(
            .LANE   (n),
            .COEF_W (COEF_W),
            .PROD_W (PROD_W),
            .ACC_W  (ACC_W),
            .OUT_W  (OUT_W)
        ) u_lane (
            .clk_i    (clk_i),
            .rst_ni   (rst_ni),
            .take_i   (coef_valid_i),
            .first_i  (first),
            .last_i   (last),
            .prod_i   (prods),
            .sample_o (samples_o[n*OUT_W +: OUT_W])
        );
    end

    // R4
    done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |=> !done_o);

    // R4
    done_after_take_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |-> $past(coef_valid_i));

    // R6
    done_restart_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(done_o) |-> (ctl_q.cnt == '0));

endmodule

// File: tb/idct8_engine_test.sv
module idct8_engine_test;

    localparam int CLK_PERIOD = 10;
    localparam int COEF_W     = 12;
    localparam int OUT_W      = 9;
    localparam int NPT        = 8;
    localparam int WATCHDOG   = 100000;
    localparam real PI        = 3.14159265358979;

    logic                    clk = 1'b0;
    logic                    rst_n = 1'b0;
    logic                    vld = 1'b0;
    logic [COEF_W-1:0]       coef = '0;
    logic                    done;
    logic [NPT*OUT_W-1:0]    samples;

    always #(CLK_PERIOD/2) clk = ~clk;

    idct8_engine uut (
        .clk_i        (clk),
        .rst_ni       (rst_n),
        .coef_valid_i (vld),
        .coef_i       (coef),
        .done_o       (done),
        .samples_o    (samples)
    );

    int    checks = 0;
    int    errors = 0;
    int    cycles = 0;
    int    blk_q[$];
    int    exp_s[NPT];
    int    held[NPT];
    bit    exp_done = 1'b0;
    bit    hold_active = 1'b0;
    string exp_tag = "R2";

    function automatic int got(int n);
        logic signed [OUT_W-1:0] v;
        v = samples[n*OUT_W +: OUT_W];
        return int'(v);
    endfunction

    function automatic int ref_sample(int n, int x[NPT]);
        real s;
        real r;
        int  q;
        s = 0.0;
        for (int k = 0; k < NPT; k++) begin
            real ck;
            ck = (k == 0) ? (1.0 / $sqrt(2.0)) : 1.0;
            s += ck * real'(x[k]) * $cos(real'((2*n+1)*k) * PI / 16.0);
        end
        r = $floor(0.5 * s + 0.5);
        q = int'(r);
        if (q > 255)  q = 255;
        if (q < -256) q = -256;
        return q;
    endfunction

    task automatic check_int(string rq, string what, int act, int expv, int tol);
        checks++;
        if (act > expv + tol || act < expv - tol) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", rq, what, act, expv);
        end
    endtask

    task automatic do_checks();
        check_int("R4", "done", int'(done), int'(exp_done), 0);
        if (exp_done) begin
            for (int n = 0; n < NPT; n++) begin
                check_int(exp_tag, $sformatf("sample%0d", n), got(n), exp_s[n], 1);
                held[n] = got(n);
            end
            hold_active = 1'b1;
        end else if (hold_active) begin
            for (int n = 0; n < NPT; n++) begin
                check_int("R5", $sformatf("held sample%0d", n), got(n), held[n], 0);
            end
        end
    endtask

    task automatic step(bit v, int c, string tag);
        @(negedge clk);
        do_checks();
        vld      = v;
        coef     = COEF_W'(c);
        exp_done = 1'b0;
        if (v) begin
            hold_active = 1'b0;
            blk_q.push_back(c);
            if (blk_q.size() == NPT) begin
                int x[NPT];
                for (int k = 0; k < NPT; k++) x[k] = blk_q[k];
                for (int n = 0; n < NPT; n++) exp_s[n] = ref_sample(n, x);
                blk_q.delete();
                exp_done = 1'b1;
                exp_tag  = tag;
            end
        end
    endtask

    task automatic send_block(int x[NPT], string tag, int gap);
        for (int k = 0; k < NPT; k++) begin
            step(1'b1, x[k], tag);
            if (k < NPT - 1) begin
                for (int g = 0; g < gap; g++) step(1'b0, 0, tag);
            end
        end
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > WATCHDOG) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual %0d cycles expected at most %0d", cycles, WATCHDOG);
            finish_run();
        end
    end

    initial begin
        int x[NPT];
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        check_int("R1", "done", int'(done), 0, 0);
        for (int n = 0; n < NPT; n++) check_int("R1", $sformatf("sample%0d", n), got(n), 0, 0);

        // R3: DC-only blocks
        x = '{64, 0, 0, 0, 0, 0, 0, 0};
        send_block(x, "R3", 0);
        x = '{-300, 0, 0, 0, 0, 0, 0, 0};
        send_block(x, "R3", 0);
        step(1'b0, 0, "R5");
        step(1'b0, 0, "R5");

        // R8: single-coefficient blocks at every index
        for (int k = 0; k < NPT; k++) begin
            for (int j = 0; j < NPT; j++) x[j] = (j == k) ? 400 : 0;
            send_block(x, "R8", 0);
        end
        x = '{0, 0, 0, 0, 0, 0, 0, -350};
        send_block(x, "R8", 1);

        // R2: random blocks, R6: back-to-back
        for (int b = 0; b < 40; b++) begin
            for (int j = 0; j < NPT; j++) x[j] = int'($urandom_range(0, 300)) - 150;
            send_block(x, (b % 2 == 0) ? "R2" : "R6", 0);
        end

        // R5: idle cycles inside blocks
        for (int b = 0; b < 6; b++) begin
            for (int j = 0; j < NPT; j++) x[j] = int'($urandom_range(0, 200)) - 100;
            send_block(x, "R5", b % 3 + 1);
            step(1'b0, 0, "R5");
        end

        // R7: saturation both ways
        x = '{2047, 2047, 2047, 2047, 2047, 2047, 2047, 2047};
        send_block(x, "R7", 0);
        x = '{-2048, -2048, -2048, -2048, -2048, -2048, -2048, -2048};
        send_block(x, "R7", 0);
        x = '{2047, -2048, 2047, -2048, 2047, -2048, 2047, -2048};
        send_block(x, "R7", 0);
        x = '{0, 2047, 0, 0, 0, 0, 0, 0};
        send_block(x, "R7", 0);

        // R6: recovery to a small block right after saturation
        x = '{10, -5, 3, 0, 0, 2, 0, -1};
        send_block(x, "R6", 0);

        repeat (3) step(1'b0, 0, "R5");
        finish_run();
    end

endmodule